// File: doc/BRIEF.md
# Supervisor Reset and Power-Fail Output

This block turns two digital comparator flags and an external reset request into an active-low system reset and a power-fail warning output. One flag reports that the supply is inside its valid window. The other reports that a monitored input, usually a divided raw supply, is above its threshold. While the supply flag is low, the reset is held low and the power-fail output is driven low, as it is during battery backup. Once the supply becomes valid, a stretch timer keeps the reset asserted for a fixed number of clock cycles so that the supply and the processor can settle.

During that post-supply interval the power-fail output is pinned high whatever the comparator says. It is released on the same clock edge as the reset, and from then on it mirrors the comparator flag. An external active-low reset request is synchronised, then filtered by a low-level counter so that short glitches have no effect. A request that qualifies pulls the reset low and restarts the same stretch timer, so a requested reset lasts exactly as long as one caused by a power cycle.

The supply-valid flag doubles as the asynchronous initialiser of every register in the block. Its rising edge is expected to be synchronous to the clock.

Top module: `supv_reset_pf`

## Requirements
- R1: While `supplyOk` is low, `sysRstN` and `pfOut` are both low, whatever `reqN` and `pfiFlag` do.
- R2: When `supplyOk` goes high between two clock edges with `reqN` high, `sysRstN` goes high right after the `STRETCH_CYC`-th rising edge that follows.
- R3: If `supplyOk` drops at any point in the stretch interval, the interval starts again in full, measured from the next return of `supplyOk`.
- R4: A `reqN` low level that the clock samples on `QUAL_CYC` or more consecutive edges drives `sysRstN` low. The drop follows edge number `QUAL_CYC`+2, counting the first edge that samples the low as edge 1.
- R5: A `reqN` low level that is sampled on fewer than `QUAL_CYC` consecutive edges, a single-cycle glitch included, leaves `sysRstN` high.
- R6: The reset from a qualified request is held as long as `reqN` stays low. `sysRstN` returns high right after edge number `STRETCH_CYC`+2, counting the first edge that samples `reqN` high as edge 1.
- R7: A new qualifying request that arrives while a stretch is running restarts the stretch, so the release is measured from the end of the newest request.
- R8: For the whole stretch that follows a rise of `supplyOk`, `pfOut` is high even when `pfiFlag` is low. The forced-high phase ends on the same edge on which `sysRstN` rises.
- R9: With the supply valid and no post-supply stretch running, `pfOut` equals `pfiFlag` in the same cycle. This also holds while a reset started by a request is in progress. A low `pfiFlag` means the monitored input is below its threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| supplyOk | input | 1 | Supply-valid comparator flag, high when the supply is above the detect level; low also initialises every register |
| reqN | input | 1 | Asynchronous active-low reset request |
| pfiFlag | input | 1 | Power-fail comparator flag, high when the monitored input is above threshold |
| sysRstN | output | 1 | Active-low system reset |
| pfOut | output | 1 | Power-fail output, low on a warning or in battery backup |

## Verification
The assertions assume that `supplyOk` rises synchronously to the clock and that each low phase of it covers at least one clock edge. They also assume that `pfiFlag` is already a clean synchronous flag, because it reaches `pfOut` without a register. The bench respects these assumptions by changing every input two time units after a rising edge, well away from the next edge, and by never leaving the supply low for less than a whole cycle. Request pulse widths are drawn at random on both sides of the qualifying width, and directed cases cover exactly one cycle short of that width and a request that arrives while a stretch is already running.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Number of flops on the asynchronous request path.
  localparam int unsigned SYNC_STAGES = 2;

  // Control -> datapath strobes.
  typedef struct packed {
    logic timerLoad;   // restart the stretch timer at its full value
    logic timerRun;    // let the stretch timer count down
  } ctlStrobes_t;

  // Datapath -> control status.
  typedef struct packed {
    logic qualHeld;    // filtered request is low and has met the width
    logic timerZero;   // stretch timer has expired
  } dpStatus_t;

  typedef enum logic [1:0] {
    ST_PWRUP  = 2'd0,  // post-supply stretch, power-fail output pinned high
    ST_EXTRST = 2'd1,  // stretch started by a request, output follows flag
    ST_RUN    = 2'd2   // normal operation
  } supvState_t;

endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 12_000_000,
  parameter int unsigned QUAL_CYC    = 20
) (
  input  logic        clk,
  input  logic        supplyOk,
  input  logic        reqN,
  input  ctlStrobes_t strobes,
  output dpStatus_t   status
);

  localparam int unsigned TW = $clog2(STRETCH_CYC + 1);
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam logic [TW-1:0] TIMER_FULL = TW'(STRETCH_CYC - 1);
  localparam logic [QW-1:0] QUAL_SAT   = QW'(QUAL_CYC - 1);

  // Request synchroniser, idle high.
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   reqSynced;

  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) syncChain <= '1;
    else           syncChain <= {syncChain[SYNC_STAGES-2:0], reqN};
  end

  assign reqSynced = syncChain[SYNC_STAGES-1];

  // Low-level width counter, saturating at the qualifying width.
  logic [QW-1:0] lowCnt;

  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk)             lowCnt <= '0;
    else if (reqSynced)        lowCnt <= '0;
    else if (lowCnt != QUAL_SAT) lowCnt <= lowCnt + 1'b1;
  end

  // Shared stretch timer.
  logic [TW-1:0] stretchCnt;

  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk)                             stretchCnt <= TIMER_FULL;
    else if (strobes.timerLoad)                stretchCnt <= TIMER_FULL;
    else if (strobes.timerRun && stretchCnt != '0) stretchCnt <= stretchCnt - 1'b1;
  end

  assign status.qualHeld  = !reqSynced && (lowCnt == QUAL_SAT);
  assign status.timerZero = (stretchCnt == '0);

endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        supplyOk,
  input  logic        pfiFlag,
  input  dpStatus_t   status,
  output ctlStrobes_t strobes,
  output logic        sysRstN,
  output logic        pfOut
);

  supvState_t state, stateNxt;

  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) state <= ST_PWRUP;
    else           state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_PWRUP, ST_EXTRST: begin
        if (!status.qualHeld && status.timerZero) stateNxt = ST_RUN;
      end
      ST_RUN: begin
        if (status.qualHeld) stateNxt = ST_EXTRST;
      end
      default: stateNxt = ST_PWRUP;
    endcase
  end

  // A held, qualified request keeps reloading the timer in every state.
  assign strobes.timerLoad = status.qualHeld;
  assign strobes.timerRun  = (state != ST_RUN);

  assign sysRstN = supplyOk && (state == ST_RUN);
  assign pfOut   = supplyOk && ((state == ST_PWRUP) ? 1'b1 : pfiFlag);

endmodule

// File: rtl/supv_reset_pf.sv
module supv_reset_pf
  import supv_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 12_000_000,
  parameter int unsigned QUAL_CYC    = 20
) (
  input  logic clk,
  input  logic supplyOk,
  input  logic reqN,
  input  logic pfiFlag,
  output logic sysRstN,
  output logic pfOut
);

  ctlStrobes_t strobes;
  dpStatus_t   status;

  supv_datapath #(
    .STRETCH_CYC (STRETCH_CYC),
    .QUAL_CYC    (QUAL_CYC)
  ) u_datapath (
    .clk      (clk),
    .supplyOk (supplyOk),
    .reqN     (reqN),
    .strobes  (strobes),
    .status   (status)
  );

  supv_control u_control (
    .clk      (clk),
    .supplyOk (supplyOk),
    .pfiFlag  (pfiFlag),
    .status   (status),
    .strobes  (strobes),
    .sysRstN  (sysRstN),
    .pfOut    (pfOut)
  );

endmodule

// File: rtl/supv_reset_pf_chk.sv
module supv_reset_pf_chk #(
  parameter int unsigned STRETCH_CYC = 12_000_000,
  parameter int unsigned QUAL_CYC    = 20
) (
  input logic clk,
  input logic supplyOk,
  input logic reqN,
  input logic pfiFlag,
  input logic sysRstN,
  input logic pfOut
);

  localparam int unsigned LW = $clog2(QUAL_CYC + 3);
  localparam int unsigned HW = $clog2(STRETCH_CYC + 1);
  localparam logic [LW-1:0] LOW_SAT = LW'(QUAL_CYC + 2);
  localparam logic [HW-1:0] HI_SAT  = HW'(STRETCH_CYC);

  // Consecutive edges with the raw request low.
  logic [LW-1:0] lowRun;
  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk)          lowRun <= '0;
    else if (reqN)          lowRun <= '0;
    else if (lowRun != LOW_SAT) lowRun <= lowRun + 1'b1;
  end

  // Consecutive edges with a valid supply and the raw request high.
  logic [HW-1:0] hiRun;
  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk)        hiRun <= '0;
    else if (!reqN)       hiRun <= '0;
    else if (hiRun != HI_SAT) hiRun <= hiRun + 1'b1;
  end

  // Set by a supply loss, cleared once the reset has been released.
  logic inPowerUp;
  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk)    inPowerUp <= 1'b1;
    else if (sysRstN) inPowerUp <= 1'b0;
  end

  // R1
  always_comb begin
    if (!supplyOk) begin
      p_outputs_low_r1: assert (!sysRstN && !pfOut);
    end
  end

  // R2, R3, R6: no release before a full stretch of high request
  p_full_stretch_r2: assert property (@(posedge clk) disable iff (!supplyOk)
    $rose(sysRstN) |-> (hiRun >= HI_SAT));

  // R4, R5: a request-driven reset needs a qualifying low run
  p_qualified_only_r5: assert property (@(posedge clk) disable iff (!supplyOk)
    $fell(sysRstN) |-> ($past(lowRun, 2) >= LW'(QUAL_CYC)));

  // R8
  p_forced_high_r8: assert property (@(posedge clk) disable iff (!supplyOk)
    (inPowerUp && !sysRstN) |-> pfOut);

  // R8, R9
  p_follow_flag_r9: assert property (@(posedge clk) disable iff (!supplyOk)
    sysRstN |-> (pfOut == pfiFlag));

  // R6: the reset stays low while the request is held low for long
  p_held_low_r6: assert property (@(posedge clk) disable iff (!supplyOk)
    (!sysRstN && lowRun == LOW_SAT) |=> !sysRstN);

endmodule

bind supv_reset_pf supv_reset_pf_chk #(
  .STRETCH_CYC (STRETCH_CYC),
  .QUAL_CYC    (QUAL_CYC)
) u_chk (
  .clk      (clk),
  .supplyOk (supplyOk),
  .reqN     (reqN),
  .pfiFlag  (pfiFlag),
  .sysRstN  (sysRstN),
  .pfOut    (pfOut)
);

// File: tb/test_supv_reset_pf.sv
module test_supv_reset_pf;

  localparam int STRETCH = 40;
  localparam int QUAL    = 6;

  logic clk = 1'b0;
  logic supplyOk = 1'b0;
  logic reqN = 1'b1;
  logic pfiFlag = 1'b0;
  logic sysRstN;
  logic pfOut;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  supv_reset_pf #(
    .STRETCH_CYC (STRETCH),
    .QUAL_CYC    (QUAL)
  ) i_supv_reset_pf (
    .clk      (clk),
    .supplyOk (supplyOk),
    .reqN     (reqN),
    .pfiFlag  (pfiFlag),
    .sysRstN  (sysRstN),
    .pfOut    (pfOut)
  );

  function automatic logic expectReset(int width);
    return width >= QUAL;
  endfunction

  task automatic checkBit(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic checkInt(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Counts edges until sysRstN reaches lvl, forcedOk tracks pfOut high.
  task automatic waitLevel(logic lvl, output int n, output logic forcedOk);
    n = 0;
    forcedOk = 1'b1;
    do begin
      step();
      n++;
      if (!sysRstN && !pfOut) forcedOk = 1'b0;
    end while (sysRstN !== lvl && n < STRETCH + 50);
  endtask

  // Drives a request pulse of the given width and judges the outcome.
  task automatic pulseReq(int width, string req);
    logic sawLow;
    int   lastLow;
    sawLow  = 1'b0;
    lastLow = 0;
    reqN = 1'b0;
    for (int i = 0; i < width; i++) begin
      step();
      if (!sysRstN) sawLow = 1'b1;
    end
    reqN = 1'b1;
    for (int i = 1; i <= STRETCH + QUAL + 10; i++) begin
      step();
      if (!sysRstN) begin
        sawLow  = 1'b1;
        lastLow = i;
      end
    end
    checkBit(req, "reset taken for pulse width", sawLow, expectReset(width));
    if (expectReset(width))
      checkInt("R6", "release edge after request end", lastLow + 1, STRETCH + 2);
  endtask

  initial begin
    int   n;
    logic okF;
    void'($urandom(32'd1234));

    // Reset state with supply invalid
    pfiFlag = 1'b1;
    reqN = 1'b0;
    repeat (3) step();
    checkBit("R1", "sysRstN supply low", sysRstN, 1'b0);
    checkBit("R1", "pfOut supply low", pfOut, 1'b0);
    reqN = 1'b1;

    // Power-up stretch with pfiFlag low
    pfiFlag = 1'b0;
    supplyOk = 1'b1;
    waitLevel(1'b1, n, okF);
    checkInt("R2", "edges to release after supply", n, STRETCH);
    checkBit("R8", "pfOut forced high in stretch", okF, 1'b1);
    checkBit("R8", "pfOut released with reset", pfOut, 1'b0);

    // Normal following
    pfiFlag = 1'b1; #1;
    checkBit("R9", "pfOut follows high", pfOut, 1'b1);
    pfiFlag = 1'b0; #1;
    checkBit("R9", "pfOut follows low", pfOut, 1'b0);

    // Supply loss in the stretch restarts it
    supplyOk = 1'b0;
    step();
    checkBit("R1", "sysRstN after loss", sysRstN, 1'b0);
    step();
    supplyOk = 1'b1;
    repeat (15) step();
    checkBit("R3", "still held mid stretch", sysRstN, 1'b0);
    supplyOk = 1'b0;
    repeat (2) step();
    supplyOk = 1'b1;
    waitLevel(1'b1, n, okF);
    checkInt("R3", "edges to release after restart", n, STRETCH);

    // Qualified request, held, then released
    reqN = 1'b0;
    waitLevel(1'b0, n, okF);
    checkInt("R4", "edges to reset after request", n, QUAL + 2);
    pfiFlag = 1'b1; #1;
    checkBit("R9", "pfOut follows in request reset", pfOut, 1'b1);
    pfiFlag = 1'b0; #1;
    checkBit("R9", "pfOut low in request reset", pfOut, 1'b0);
    repeat (STRETCH + 5) step();
    checkBit("R6", "held while request low", sysRstN, 1'b0);
    reqN = 1'b1;
    waitLevel(1'b1, n, okF);
    checkInt("R6", "edges to release after request", n, STRETCH + 2);

    // Glitches
    pulseReq(1, "R5");
    pulseReq(QUAL - 1, "R5");
    pulseReq(QUAL, "R4");

    // Restart by a second request during the stretch
    reqN = 1'b0;
    repeat (QUAL + 3) step();
    reqN = 1'b1;
    repeat (15) step();
    checkBit("R7", "still in first stretch", sysRstN, 1'b0);
    reqN = 1'b0;
    repeat (QUAL + 3) step();
    reqN = 1'b1;
    waitLevel(1'b1, n, okF);
    checkInt("R7", "release measured from second request", n, STRETCH + 2);

    // Random pulse widths and comparator levels
    for (int k = 0; k < 30; k++) begin
      int w;
      w = $urandom_range(1, 2 * QUAL);
      pulseReq(w, expectReset(w) ? "R4" : "R5");
      pfiFlag = 1'($urandom_range(0, 1)); #1;
      checkBit("R9", "pfOut random flag", pfOut, pfiFlag);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule